// File: doc/BRIEF.md
# Multi-Page-Size TLB Lookup Unit

This block is the lookup path of a fully associative translation buffer. The entry table is held elsewhere and presented as two flat vectors: one tag word and one translation word per entry. A request carries a virtual address, the current 13-bit context, a user/privileged flag and a read/write flag. All entries are compared in parallel. One cycle later the block reports hit or miss, the physical address and a permission fault.

Each entry carries its own page size, so each comparator applies its own address mask. A protection violation updates a fault status register, which flags overflow when a new fault arrives before the previous one is cleared, and a fault address register. A miss loads a tag-access register for the refill handler. When translation is disabled, the address passes through unchanged and nothing is recorded.

Top module: `tlb_lookup_unit`

## Requirements
- R1: An entry takes part in matching only if bit 63 of its translation word is 1. A lookup that matches only invalid entries is a miss.
- R2: Translation-word bits 62:61 give the page size. Code 0 is 8 KB, 1 is 64 KB, 2 is 512 KB and 3 is 4 MB. The compare mask is ones from bit 13 upward, shifted left by 3 bits per code step. The virtual address and the tag must agree under that mask.
- R3: A hit also requires tag bits 12:0 to equal the request context.
- R4: On a translated hit, `paddr_o` = ((translation word AND mask) OR (address AND NOT mask)), kept to bits 40:13. All other bits are 0.
- R5: When several valid entries match, the entry with the lowest index supplies the translation.
- R6: A request sampled with `lookup_valid_i` high at a rising edge produces `valid_o` high for exactly the following cycle, together with the result.
- R7: A hit on an entry with translation-word bit 2 set, requested with `user_i` = 1, is a privilege fault: `fault_o` = 1 and `hit_o` = 1.
- R8: A hit with `write_i` = 1 on an entry whose translation-word bit 1 is 0 is a write fault.
- R9: On a fault, the status register becomes base OR 1 OR (`write_i` << 2) OR (`user_i` << 3) OR (type << 7). Type bit 0 means privilege violation. Base is the previous value when its bit 0 is clear. The fault address register takes the virtual address.
- R10: When a fault arrives while status bit 0 is already 1, the base is the value 2, which marks overflow.
- R11: On a miss, the tag-access register becomes the virtual address with bits 12:0 replaced by the context.
- R12: With `enable_i` = 0, the result is a hit with `paddr_o` equal to `vaddr_i`, no fault and no miss. The fault status, fault address and tag-access registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lookup_valid_i | input | 1 | Request strobe |
| enable_i | input | 1 | Translation enabled |
| vaddr_i | input | 64 | Virtual address |
| context_i | input | 13 | Current primary context |
| user_i | input | 1 | 1 = user access, 0 = privileged access |
| write_i | input | 1 | 1 = write, 0 = read |
| tag_array_i | input | 4096 | Tag words, entry k at bits 64k+63:64k |
| tte_array_i | input | 4096 | Translation words, entry k at bits 64k+63:64k |
| valid_o | output | 1 | Result valid |
| hit_o | output | 1 | Translation found (or bypass) |
| miss_o | output | 1 | No matching entry |
| fault_o | output | 1 | Protection violation |
| paddr_o | output | 64 | Physical address |
| fault_status_o | output | 64 | Fault status register |
| fault_addr_o | output | 64 | Fault address register |
| tag_access_o | output | 64 | Tag-access register |

## Verification
Lookups are made against each of the four page sizes. Offsets are chosen inside a page and just beyond its end, so that a correct per-entry mask can be told apart from a fixed one. Some requests differ from a stored entry only in the context or only in the valid bit, which separates the three hit conditions from one another. Two entries mapping the same page expose the priority order. A sequence of privilege and write faults, each followed by a clean access, shows the first-fault encoding, the overflow rewrite and the fault-type field. Disabled lookups that would otherwise fault show that the bypass leaves every register untouched.

// File: rtl/tlb_lookup_pkg.sv
package tlb_lookup_pkg;
  localparam int WORD_W    = 64;
  localparam int CTX_W     = 13;
  localparam int VALID_BIT = 63;
  localparam int SIZE_LO   = 61;
  localparam int PRIV_BIT  = 2;
  localparam int WR_BIT    = 1;
  localparam int FTYPE_LSB = 7;

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t BASE_MASK = ~word_t'((64'd1 << CTX_W) - 64'd1);
  localparam word_t PA_KEEP   = 64'h0000_01ff_ffff_e000;
  localparam word_t FSR_OVF   = 64'd2;

  function automatic word_t page_mask(input logic [1:0] size_code);
    return BASE_MASK << (3 * int'(size_code));
  endfunction
endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_lookup_pkg::*;
(
  input  word_t             tag_i,
  input  word_t             tte_i,
  input  word_t             vaddr_i,
  input  logic [CTX_W-1:0]  ctx_i,
  output logic              match_o
);
  word_t mask;
  logic  ctx_eq, va_eq;

  always_comb begin
    mask    = page_mask(tte_i[SIZE_LO+1:SIZE_LO]);
    ctx_eq  = (tag_i[CTX_W-1:0] == ctx_i);
    va_eq   = (((vaddr_i ^ tag_i) & mask) == '0);
    match_o = tte_i[VALID_BIT] && ctx_eq && va_eq;
  end
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [N_ENTRIES-1:0] match_i,
  output logic                 any_o,
  output logic [IDX_W-1:0]     idx_o,
  output logic [N_ENTRIES-1:0] grant_o
);
  always_comb begin
    idx_o   = '0;
    grant_o = '0;
    any_o   = |match_i;
    // scan downward so the lowest matching index is the last written
    for (int k = N_ENTRIES - 1; k >= 0; k--) begin
      if (match_i[k]) begin
        idx_o   = IDX_W'(k);
        grant_o = '0;
        grant_o[k] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_fault_track.sv
module tlb_fault_track
  import tlb_lookup_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fault_evt_i,
  input  logic             miss_evt_i,
  input  logic             priv_viol_i,
  input  logic             user_i,
  input  logic             write_i,
  input  word_t            vaddr_i,
  input  logic [CTX_W-1:0] ctx_i,
  output word_t            fsr_o,
  output word_t            far_o,
  output word_t            tag_access_o
);
  word_t fsr_q, far_q, tacc_q;
  word_t fsr_base, fsr_next;

  always_comb begin
    fsr_base = fsr_q[0] ? FSR_OVF : fsr_q;
    fsr_next = fsr_base
             | (word_t'(priv_viol_i) << FTYPE_LSB)
             | (word_t'(user_i) << 3)
             | (word_t'(write_i) << 2)
             | word_t'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q  <= '0;
      far_q  <= '0;
      tacc_q <= '0;
    end else begin
      if (fault_evt_i) begin
        fsr_q <= fsr_next;
        far_q <= vaddr_i;
      end
      if (miss_evt_i) tacc_q <= {vaddr_i[WORD_W-1:CTX_W], ctx_i};
    end
  end

  assign fsr_o        = fsr_q;
  assign far_o        = far_q;
  assign tag_access_o = tacc_q;

  p_overflow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt_i && fsr_q[0] |=> fsr_q[1] && fsr_q[0]);
  p_fault_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_evt_i |=> far_q == $past(vaddr_i));
  p_fsr_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_evt_i |=> $stable(fsr_q));
  p_tag_access_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_evt_i |=> tacc_q == {$past(vaddr_i[WORD_W-1:CTX_W]), $past(ctx_i)});
endmodule

// File: rtl/tlb_lookup_unit.sv
module tlb_lookup_unit
  import tlb_lookup_pkg::*;
#(
  parameter int N_ENTRIES = 64,
  localparam int IDX_W    = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1,
  localparam int ARR_W    = N_ENTRIES * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lookup_valid_i,
  input  logic             enable_i,
  input  logic [63:0]      vaddr_i,
  input  logic [12:0]      context_i,
  input  logic             user_i,
  input  logic             write_i,
  input  logic [ARR_W-1:0] tag_array_i,
  input  logic [ARR_W-1:0] tte_array_i,
  output logic             valid_o,
  output logic             hit_o,
  output logic             miss_o,
  output logic             fault_o,
  output logic [63:0]      paddr_o,
  output logic [63:0]      fault_status_o,
  output logic [63:0]      fault_addr_o,
  output logic [63:0]      tag_access_o
);
  logic [N_ENTRIES-1:0] match, grant;
  logic                 any_hit;
  logic [IDX_W-1:0]     sel_idx;

  for (genvar k = 0; k < N_ENTRIES; k++) begin : g_cmp
    tlb_entry_match i_match (
      .tag_i   (tag_array_i[k*WORD_W +: WORD_W]),
      .tte_i   (tte_array_i[k*WORD_W +: WORD_W]),
      .vaddr_i (vaddr_i),
      .ctx_i   (context_i),
      .match_o (match[k])
    );
  end

  tlb_prio_pick #(.N_ENTRIES(N_ENTRIES)) i_pick (
    .match_i (match),
    .any_o   (any_hit),
    .idx_o   (sel_idx),
    .grant_o (grant)
  );

  word_t sel_tte, sel_mask, pa_xlat;
  logic  priv_viol, wr_viol, xl_fault, xl_miss;

  always_comb begin
    sel_tte   = tte_array_i[int'(sel_idx)*WORD_W +: WORD_W];
    sel_mask  = page_mask(sel_tte[SIZE_LO+1:SIZE_LO]);
    pa_xlat   = ((sel_tte & sel_mask) | (vaddr_i & ~sel_mask)) & PA_KEEP;
    priv_viol = any_hit && sel_tte[PRIV_BIT] && user_i;
    wr_viol   = any_hit && !sel_tte[WR_BIT] && write_i;
    xl_fault  = lookup_valid_i && enable_i && (priv_viol || wr_viol);
    xl_miss   = lookup_valid_i && enable_i && !any_hit;
  end

  tlb_fault_track i_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_evt_i  (xl_fault),
    .miss_evt_i   (xl_miss),
    .priv_viol_i  (priv_viol),
    .user_i       (user_i),
    .write_i      (write_i),
    .vaddr_i      (vaddr_i),
    .ctx_i        (context_i),
    .fsr_o        (fault_status_o),
    .far_o        (fault_addr_o),
    .tag_access_o (tag_access_o)
  );

  logic  valid_q, hit_q, miss_q, fault_q;
  word_t paddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      miss_q  <= 1'b0;
      fault_q <= 1'b0;
      paddr_q <= '0;
    end else begin
      valid_q <= lookup_valid_i;
      if (!lookup_valid_i) begin
        hit_q   <= 1'b0;
        miss_q  <= 1'b0;
        fault_q <= 1'b0;
      end else if (!enable_i) begin
        hit_q   <= 1'b1;
        miss_q  <= 1'b0;
        fault_q <= 1'b0;
        paddr_q <= vaddr_i;
      end else begin
        hit_q   <= any_hit;
        miss_q  <= !any_hit;
        fault_q <= xl_fault;
        paddr_q <= pa_xlat;
      end
    end
  end

  assign valid_o = valid_q;
  assign hit_o   = hit_q;
  assign miss_o  = miss_q;
  assign fault_o = fault_q;
  assign paddr_o = paddr_q;

  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> valid_o);
  p_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !valid_o && !hit_o && !fault_o && !miss_o);
  p_single_grant_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant) && (any_hit == (grant != '0)));
  p_fault_on_hit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> hit_o && valid_o && !miss_o);
  p_pa_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i && enable_i |=> paddr_o[12:0] == '0 && paddr_o[63:41] == '0);
  p_bypass_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i && !enable_i |=> paddr_o == $past(vaddr_i) && hit_o && !fault_o && !miss_o);
endmodule

// File: tb/test_tlb_lookup_unit.sv
module test_tlb_lookup_unit;
  localparam int N = 64;
  localparam logic [63:0] V  = 64'h8000_0000_0000_0000;
  localparam logic [63:0] WR = 64'h2;
  localparam logic [63:0] PR = 64'h4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lookup_valid = 1'b0, enable = 1'b1, user = 1'b0, write = 1'b0;
  logic [63:0] vaddr = '0;
  logic [12:0] ctx = '0;
  logic [N*64-1:0] tag_flat = '0, tte_flat = '0;
  logic valid, hit, miss, fault;
  logic [63:0] paddr, fsr, far, tacc;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  tlb_lookup_unit #(.N_ENTRIES(N)) i_tlb_lookup_unit (
    .clk_i(clk), .rst_ni(rst_n), .lookup_valid_i(lookup_valid), .enable_i(enable),
    .vaddr_i(vaddr), .context_i(ctx), .user_i(user), .write_i(write),
    .tag_array_i(tag_flat), .tte_array_i(tte_flat),
    .valid_o(valid), .hit_o(hit), .miss_o(miss), .fault_o(fault), .paddr_o(paddr),
    .fault_status_o(fsr), .fault_addr_o(far), .tag_access_o(tacc)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic put_entry(input int k, input logic [63:0] tag, input logic [63:0] tte);
    tag_flat[k*64 +: 64] = tag;
    tte_flat[k*64 +: 64] = tte;
  endtask

  // drive one request, return after the result edge, sampled at negedge
  task automatic lookup(input logic en, input logic [63:0] va, input logic [12:0] c,
                        input logic u, input logic w);
    @(negedge clk);
    lookup_valid = 1'b1; enable = en; vaddr = va; ctx = c; user = u; write = w;
    @(negedge clk);
    lookup_valid = 1'b0;
  endtask

  task automatic t_reset;
    chk("R6 reset valid", 64'(valid), 64'd0);
    chk("R9 reset fsr", fsr, 64'd0);
    chk("R9 reset far", far, 64'd0);
    chk("R11 reset tag access", tacc, 64'd0);
  endtask

  task automatic t_basic_hit;
    lookup(1'b1, 64'h0000_0000_1234_6abc, 13'd5, 1'b0, 1'b0);
    chk("R6 valid after request", 64'(valid), 64'd1);
    chk("R3 hit on context 5", 64'(hit), 64'd1);
    chk("R4 8K paddr", paddr, 64'h0000_0055_5555_4000);
    chk("R8 read no fault", 64'(fault), 64'd0);
    @(negedge clk);
    chk("R6 valid one cycle", 64'(valid), 64'd0);
  endtask

  task automatic t_context_miss;
    lookup(1'b1, 64'h0000_0000_1234_6abc, 13'd6, 1'b0, 1'b0);
    chk("R3 wrong context miss", 64'(miss), 64'd1);
    chk("R3 wrong context hit", 64'(hit), 64'd0);
    chk("R11 tag access", tacc, 64'h0000_0000_1234_6006);
  endtask

  task automatic t_invalid;
    lookup(1'b1, 64'h0000_0000_2000_0010, 13'd7, 1'b0, 1'b0);
    chk("R1 invalid entry miss", 64'(miss), 64'd1);
    chk("R11 tag access invalid", tacc, 64'h0000_0000_2000_0007);
  endtask

  task automatic t_sizes;
    lookup(1'b1, 64'h0000_0000_4000_e123, 13'd9, 1'b0, 1'b0);
    chk("R2 64K hit", 64'(hit), 64'd1);
    chk("R4 64K paddr", paddr, 64'h0000_0012_3400_e000);
    lookup(1'b1, 64'h0000_0000_c007_ffff, 13'd9, 1'b0, 1'b0);
    chk("R2 512K hit", 64'(hit), 64'd1);
    chk("R4 512K paddr", paddr, 64'h0000_0000_000f_e000);
    lookup(1'b1, 64'h0000_0000_8012_3456, 13'd9, 1'b0, 1'b0);
    chk("R2 4M hit", 64'(hit), 64'd1);
    chk("R4 4M paddr", paddr, 64'h0000_0100_0012_2000);
    lookup(1'b1, 64'h0000_0000_c008_0000, 13'd9, 1'b0, 1'b0);
    chk("R2 past 512K end miss", 64'(miss), 64'd1);
    chk("R11 tag access boundary", tacc, 64'h0000_0000_c008_0009);
    lookup(1'b1, 64'h0000_0000_1234_8000, 13'd5, 1'b0, 1'b0);
    chk("R2 past 8K end miss", 64'(miss), 64'd1);
    lookup(1'b1, 64'h0000_0000_1234_6000, 13'd5, 1'b0, 1'b0);
    chk("R11 tag access held on hit", tacc, 64'h0000_0000_1234_8005);
  endtask

  task automatic t_priority;
    lookup(1'b1, 64'h0000_0000_0600_0010, 13'd3, 1'b0, 1'b0);
    chk("R5 lowest index wins", paddr, 64'h0000_0000_0000_a000);
  endtask

  task automatic t_faults;
    lookup(1'b1, 64'h0000_0000_0700_0044, 13'd1, 1'b1, 1'b0);
    chk("R7 user on privileged page", 64'(fault), 64'd1);
    chk("R7 fault is hit", 64'(hit), 64'd1);
    chk("R9 first fault status", fsr, 64'h89);
    chk("R9 fault address", far, 64'h0000_0000_0700_0044);
    lookup(1'b1, 64'h0000_0000_0700_0048, 13'd1, 1'b0, 1'b1);
    chk("R7 privileged access ok", 64'(fault), 64'd0);
    chk("R9 status kept", fsr, 64'h89);
    lookup(1'b1, 64'h0000_0000_0800_0008, 13'd1, 1'b0, 1'b1);
    chk("R8 write to read-only", 64'(fault), 64'd1);
    chk("R10 overflow write fault", fsr, 64'h7);
    chk("R9 fault address 2", far, 64'h0000_0000_0800_0008);
    lookup(1'b1, 64'h0000_0000_0800_0010, 13'd1, 1'b1, 1'b0);
    chk("R8 read of read-only ok", 64'(fault), 64'd0);
    lookup(1'b1, 64'h0000_0000_0800_0018, 13'd1, 1'b1, 1'b1);
    chk("R10 user write overflow", fsr, 64'hf);
    lookup(1'b1, 64'h0000_0000_0700_0020, 13'd1, 1'b1, 1'b1);
    chk("R10 privilege type overflow", fsr, 64'h8f);
  endtask

  task automatic t_bypass;
    lookup(1'b0, 64'h0000_0000_0700_0040, 13'd1, 1'b1, 1'b1);
    chk("R12 bypass paddr", paddr, 64'h0000_0000_0700_0040);
    chk("R12 bypass no fault", 64'(fault), 64'd0);
    chk("R12 bypass hit", 64'(hit), 64'd1);
    chk("R12 fsr untouched", fsr, 64'h8f);
    chk("R12 far untouched", far, 64'h0000_0000_0700_0020);
    lookup(1'b0, 64'h1234_5678_9abc_def0, 13'd2, 1'b0, 1'b0);
    chk("R12 bypass wide paddr", paddr, 64'h1234_5678_9abc_def0);
    chk("R12 bypass no miss", 64'(miss), 64'd0);
    chk("R12 tag access untouched", tacc, 64'h0000_0000_1234_8005);
  endtask

  initial begin
    put_entry(0,  64'h0000_0000_1234_6005, V | 64'h0000_0055_5555_4000 | WR);
    put_entry(1,  64'h0000_0000_2000_0007, 64'h0000_0000_0001_0000 | WR);
    put_entry(2,  64'h0000_0000_4000_0009, V | (64'd1 << 61) | 64'h0000_0012_3400_0000 | WR);
    put_entry(3,  64'h0000_0000_8000_0009, V | (64'd3 << 61) | 64'h0000_0100_0000_0000 | WR);
    put_entry(4,  64'h0000_0000_c000_0009, V | (64'd2 << 61) | 64'h0000_0000_0008_0000 | WR);
    put_entry(10, 64'h0000_0000_0600_0003, V | 64'h0000_0000_0000_a000 | WR);
    put_entry(20, 64'h0000_0000_0600_0003, V | 64'h0000_0000_0000_b000 | WR);
    put_entry(30, 64'h0000_0000_0700_0001, V | 64'h0000_0000_0000_c000 | WR | PR);
    put_entry(31, 64'h0000_0000_0800_0001, V | 64'h0000_0000_0000_d000);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic_hit();
    t_context_miss();
    t_invalid();
    t_sizes();
    t_priority();
    t_faults();
    t_bypass();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule